// File: doc/BRIEF.md
# Oversampling UART Receiver with Two-Character Buffer

This block turns an asynchronous serial line into bytes for a host. A baud tick supplies the oversampling rate. A falling edge on the line opens a frame, and the block confirms the start bit at the centre of the bit. It then samples eight data bits, least significant first, an optional ninth bit, and one stop bit. Each finished character goes into a two-entry buffer together with its own frame-error and parity-error flags. The host sees the oldest unread character and its flags, and removes that character with a one-cycle read strobe.

A character that finishes while both entries are occupied waits in the shift stage. If yet another frame starts while that is true, the block raises an overrun flag and discards the new frame. The block also offers a double-speed mode, which uses half as many samples per bit. In address-filter mode, only frames whose ninth bit is 1 are kept.

Top module: `uart_rx_top`

## Requirements
- R1: After reset the status word reads 0x00 and `rx_data` reads 0. The line is treated as idle (high).
- R2: A frame opens on a low sample seen in idle. It is kept only if the line is still low at mid-bit: sample 8 of 16, or 4 of 8 in double speed. Data bits are taken at each bit centre, LSB first. `rx_data` shows the oldest unread character, and a `rd_stb` pulse while data is available removes it.
- R3: A low pulse that is high again by mid-bit opens no frame and stores nothing.
- R4: A character's frame-error flag is 1 when its stop bit samples as 0, and 0 when it samples as 1.
- R5: When `par_en` is 1 at frame start and address-filter mode is off, a ninth bit is received as parity. Its parity is even when `par_odd` is 0 and odd when `par_odd` is 1. A mismatch sets the character's parity-error flag. Changing `par_en` afterwards does not alter that flag.
- R6: The buffer returns characters oldest first and holds two of them. Status bit 7 shows that data is available. Bit 4 (frame error) and bit 2 (parity error) belong to the oldest unread character and stay unchanged until it is read.
- R7: A third finished character waits in the shift stage. If another frame starts while both entries and the shift stage are full, status bit 3 (overrun) is set and that new frame is discarded. The waiting character is kept. The overrun flag clears on the next read.
- R8: Status bit 1 selects double speed, with 8 samples per bit instead of 16.
- R9: Status bit 0 selects address-filter mode. In this mode a ninth bit is always received, no parity is checked, and frames whose ninth bit is 0 never enter the buffer.
- R10: A `status_wr` pulse loads bits 1:0 of `status_wdata` into the two mode bits. Bits 7:2 must be written as 0, and the write leaves the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One pulse per oversampling period |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_stb | input | 1 | Pops the oldest character |
| status_wr | input | 1 | Writes the mode bits |
| status_wdata | input | 8 | Write data; bits 7:2 must be 0 |
| rx_data | output | 8 | Oldest unread character |
| status | output | 8 | {avail, 0, 0, frame err, overrun, parity err, double speed, addr filter} |

## Verification
The bench builds the block with its default 16 samples per bit and a depth of 2, and pulses the baud tick every clock. Short bit times keep frames short, so many random characters fit in a short run. A depth of 2 lets four back-to-back frames reach the overrun case: both entries full, a character waiting, and a fourth start bit. Double speed is reached by writing the mode bit, which exercises the 8-sample timing under the same build.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receiver.
// Assumes a fixed 8-bit character, which the status layout depends on.
package uart_rx_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_char_t;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS, ST_STOP} rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
// Frame engine: detects the start bit, confirms it at mid-bit, samples the
// data, ninth and stop bits, and emits one character per finished frame.
// Assumes rxd_s is already synchronised and that tick pulses once per
// oversampling period. The mode inputs are captured when the frame begins.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int SPB = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd_s,
    input  logic     dbl,
    input  logic     mpc,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     start_ok,
    output logic     done,
    output logic     keep,
    output rx_char_t chr
);
    localparam int CW = $clog2(SPB);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST_N = CW'(SPB - 1);
    localparam logic [CW-1:0] LAST_D = CW'(SPB / 2 - 1);
    localparam logic [CW-1:0] MID_N  = CW'(SPB / 2 - 1);
    localparam logic [CW-1:0] MID_D  = CW'(SPB / 4 - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W:0]   shreg;
    logic              dbl_l, mpc_l, pen_l, podd_l;
    logic [CW-1:0]     last, mid;
    logic [BW-1:0]     top_idx;

    // Sample-count limits for the mode captured at frame start.
    always_comb begin
        last    = dbl_l ? LAST_D : LAST_N;
        mid     = dbl_l ? MID_D : MID_N;
        top_idx = (pen_l || mpc_l) ? BW'(DATA_W) : BW'(DATA_W - 1);
    end

    // Frame state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            dbl_l    <= 1'b0;
            mpc_l    <= 1'b0;
            pen_l    <= 1'b0;
            podd_l   <= 1'b0;
            start_ok <= 1'b0;
            done     <= 1'b0;
            keep     <= 1'b0;
            chr      <= '0;
        end else begin
            start_ok <= 1'b0;
            done     <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: if (!rxd_s) begin
                        state <= ST_START;
                        cnt   <= '0;
                        dbl_l <= dbl;
                    end
                    ST_START: if (cnt == mid) begin
                        if (rxd_s) begin
                            state <= ST_IDLE;
                        end else begin
                            state    <= ST_BITS;
                            cnt      <= '0;
                            bidx     <= '0;
                            shreg    <= '0;
                            mpc_l    <= mpc;
                            pen_l    <= par_en && !mpc;
                            podd_l   <= par_odd;
                            start_ok <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_BITS: if (cnt == last) begin
                        cnt         <= '0;
                        shreg[bidx] <= rxd_s;
                        bidx        <= bidx + 1'b1;
                        if (bidx == top_idx) state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_STOP: if (cnt == last) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        chr.data <= shreg[DATA_W-1:0];
                        chr.ferr <= !rxd_s;
                        chr.perr <= pen_l && ((^shreg) ^ podd_l);
                        keep     <= !mpc_l || shreg[DATA_W];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_STOP);

    // R8
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BITS) |-> (cnt <= last));

    // R3
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_START && cnt == mid && rxd_s) |=> (state == ST_IDLE && !start_ok));
endmodule

// File: rtl/uart_rx_buf.sv
// Receive buffer: a DEPTH-entry FIFO of characters with their flags, plus
// one waiting slot for a character that finishes while the FIFO is full.
// Flags overrun when a frame starts while the waiting slot is occupied,
// and discards that frame. A pop in the same cycle is applied first.
// Assumes DEPTH is a power of two.
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_ok,
    input  logic     frame_end,
    input  logic     keep,
    input  rx_char_t din,
    input  logic     rd,
    output rx_char_t head,
    output logic     avail,
    output logic     ovr
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    rx_char_t        mem [DEPTH];
    rx_char_t        hold;
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic [CNTW-1:0] cnt;
    logic            hold_v, drop_q, ovr_q;
    logic            pop_ok, hold_move, accept, to_fifo, to_hold, ovr_evt;

    // Route each event: pop first, then the waiting slot, then the new character.
    always_comb begin
        pop_ok    = rd && (cnt != '0);
        hold_move = hold_v && pop_ok;
        accept    = frame_end && keep && !drop_q;
        to_fifo   = accept && !hold_move && ((cnt != CNTW'(DEPTH)) || pop_ok);
        to_hold   = accept && !to_fifo;
        ovr_evt   = start_ok && hold_v && !hold_move;
        wr_ptr    = rd_ptr + AW'(cnt);
    end

    // Storage, pointers, the waiting slot and the overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            hold   <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            hold_v <= 1'b0;
            drop_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CNTW'(to_fifo || hold_move) - CNTW'(pop_ok);
            if (hold_move)    mem[wr_ptr] <= hold;
            else if (to_fifo) mem[wr_ptr] <= din;
            if (to_hold) hold <= din;
            hold_v <= to_hold || (hold_v && !hold_move);
            if (ovr_evt)        drop_q <= 1'b1;
            else if (frame_end) drop_q <= 1'b0;
            if (ovr_evt)     ovr_q <= 1'b1;
            else if (pop_ok) ovr_q <= 1'b0;
        end
    end

    assign head  = mem[rd_ptr];
    assign avail = (cnt != '0);
    assign ovr   = ovr_q;

    // R6
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));

    // R6
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && !rd) |=> (head == $past(head)));

    // R7
    hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && !hold_move) |-> !to_hold);

    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(start_ok && hold_v));
endmodule

// File: rtl/uart_rx_top.sv
// UART receiver top: synchronises the line, holds the two mode bits,
// and joins the frame engine to the receive buffer. It also assembles the
// host status word. Assumes baud_tick pulses at SPB times the bit rate.
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int SPB   = 16,
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        rxd,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        rd_stb,
    input  logic        status_wr,
    input  logic [7:0]  status_wdata,
    output logic [7:0]  rx_data,
    output logic [7:0]  status
);
    logic [1:0] rx_sync;
    logic       mpc_m, dbl_m;
    logic       start_ok, done, keep, avail, ovr;
    rx_char_t   chr, head;

    // Two-flop synchroniser on the serial line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rxd};
    end

    // Mode bits loaded from host writes; error positions are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mpc_m <= 1'b0;
            dbl_m <= 1'b0;
        end else if (status_wr) begin
            mpc_m <= status_wdata[0];
            dbl_m <= status_wdata[1];
        end
    end

    uart_rx_frame #(.SPB(SPB)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(rx_sync[1]),
        .dbl(dbl_m), .mpc(mpc_m), .par_en(par_en), .par_odd(par_odd),
        .start_ok(start_ok), .done(done), .keep(keep), .chr(chr)
    );

    uart_rx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .frame_end(done),
        .keep(keep), .din(chr), .rd(rd_stb), .head(head), .avail(avail), .ovr(ovr)
    );

    assign rx_data = avail ? head.data : '0;
    assign status  = {avail, 2'b00, avail & head.ferr, ovr, avail & head.perr, dbl_m, mpc_m};

    // R10
    wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> (status_wdata[7:2] == 6'd0));

    // R10
    wr_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && !rd_stb && avail) |=> (status[4] == $past(status[4]) && status[2] == $past(status[2])));
endmodule

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       status_wr = 1'b0;
    logic [7:0] status_wdata = 8'h00;
    logic [7:0] rx_data;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_rx_top dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
        .status_wr(status_wr), .status_wdata(status_wdata),
        .rx_data(rx_data), .status(status)
    );

    function automatic bit exp_perr(input logic [7:0] d, input bit pb, input bit odd, input bit en);
        return en & ((^d) ^ pb ^ odd);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit has9, input bit b9, input bit stop_ok, input int spb);
        rxd = 1'b0;
        repeat (spb) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (spb) @(negedge clk);
        end
        if (has9) begin
            rxd = b9;
            repeat (spb) @(negedge clk);
        end
        if (stop_ok) begin
            rxd = 1'b1;
            repeat (spb) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (spb/2 + 2) @(negedge clk);
            rxd = 1'b1;
            repeat (spb/2 - 2) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic pop();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit mpc, input bit dbl);
        status_wdata = {6'b0, dbl, mpc};
        status_wr = 1'b1;
        @(negedge clk);
        status_wr = 1'b0;
        status_wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit pen, odd, badp, bads, pb;
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 rx_data", rx_data, 0);

        // R2 R4 R5 random frames
        for (int k = 0; k < 24; k++) begin
            d    = 8'($urandom);
            pen  = 1'($urandom);
            odd  = 1'($urandom);
            badp = ($urandom % 4) == 0;
            bads = ($urandom % 5) == 0;
            pb   = (^d) ^ odd ^ badp;
            par_en = pen;
            par_odd = odd;
            send(d, pen, pb, !bads, 16);
            chk("R2 avail", status[7], 1);
            chk("R2 data", rx_data, d);
            chk("R4 ferr", status[4], bads);
            chk("R5 perr", status[2], exp_perr(d, pb, odd, pen));
            pop();
            chk("R6 empty after read", status[7], 0);
        end

        // R5 parity enable captured at frame time
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h31, 1'b1, 1'b0, 1'b1, 16);
        par_en = 1'b0;
        @(negedge clk);
        chk("R5 perr kept after disable", status[2], 1);
        pop();

        // R6 order and per-character flags
        par_en = 1'b1; par_odd = 1'b1;
        send(8'hA5, 1'b1, 1'b0, 1'b0, 16);
        send(8'h3C, 1'b1, 1'b1, 1'b1, 16);
        chk("R6 first data", rx_data, 8'hA5);
        chk("R6 first ferr", status[4], 1);
        chk("R6 first perr", status[2], 1);
        // R10 write with zero flag bits keeps flags
        set_mode(1'b0, 1'b0);
        chk("R10 ferr kept", status[4], 1);
        chk("R10 perr kept", status[2], 1);
        pop();
        chk("R6 second data", rx_data, 8'h3C);
        chk("R6 second ferr", status[4], 0);
        chk("R6 second perr", status[2], 0);
        pop();
        par_en = 1'b0;

        // R7 overrun
        send(8'h11, 1'b0, 1'b0, 1'b1, 16);
        send(8'h22, 1'b0, 1'b0, 1'b1, 16);
        send(8'h33, 1'b0, 1'b0, 1'b1, 16);
        chk("R7 no overrun at three", status[3], 0);
        send(8'h44, 1'b0, 1'b0, 1'b1, 16);
        chk("R7 overrun set", status[3], 1);
        chk("R7 head", rx_data, 8'h11);
        pop();
        chk("R7 overrun cleared", status[3], 0);
        chk("R7 second", rx_data, 8'h22);
        pop();
        chk("R7 waiting kept", rx_data, 8'h33);
        pop();
        chk("R7 fourth lost", status[7], 0);

        // R3 glitch
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3 glitch ignored", status[7], 0);

        // R8 double speed
        set_mode(1'b0, 1'b1);
        chk("R8 mode bit", status[1], 1);
        send(8'hC3, 1'b0, 1'b0, 1'b1, 8);
        chk("R8 data", rx_data, 8'hC3);
        chk("R8 ferr", status[4], 0);
        pop();

        // R9 address filter
        set_mode(1'b1, 1'b0);
        chk("R10 mode readback", status[1:0], 2'b01);
        par_en = 1'b1;
        send(8'h5A, 1'b1, 1'b0, 1'b1, 16);
        chk("R9 data frame dropped", status[7], 0);
        send(8'h81, 1'b1, 1'b1, 1'b1, 16);
        chk("R9 address kept", rx_data, 8'h81);
        chk("R9 no parity check", status[2], 0);
        pop();
        par_en = 1'b0;
        set_mode(1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule